// File: doc/BRIEF.md
# Integer Execution Unit with Boolean Compares

This block is the integer datapath of a simple load-store processor. Each accepted operation combines operand A with operand B. Operand B is either a second register value or a 16-bit immediate widened to the datapath width. The unit computes one of the following:

- add or subtract, in signed or unsigned form
- a bitwise logic function
- a shift
- a load of the upper half of the result
- a relational test, whose outcome is written as the integer 1 or 0 into the destination rather than into a flag register

Signed add and subtract also report two's-complement overflow.

The unit has one pipeline register. An operation presented with `in_valid` in one cycle appears on `result`, `ovf` and `out_valid` after the next rising clock edge. When no operation is presented, the output register keeps its previous contents. Multiply, divide and floating-point work are handled elsewhere.

Top module: `intalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `out_valid`=0, `result`=0 and `ovf`=0.
- R2: `out_valid` equals `in_valid` from the previous edge. When `in_valid` is low, `result` and `ovf` keep their previous values.
- R3: Opcode 0x00 is signed add, 0x01 unsigned add, 0x02 signed subtract (A−B) and 0x03 unsigned subtract. All four wrap modulo 2^32.
- R4: `ovf` is 1 only for signed add or subtract when the operand and result signs show two's-complement overflow. It is 0 for every other opcode, including the unsigned forms.
- R5: Opcode 0x04 gives A AND B, 0x05 gives A OR B and 0x06 gives A XOR B.
- R6: Opcode 0x07 shifts A left logically, 0x08 shifts A right logically and 0x09 shifts A right arithmetically. The shift count is B[4:0] and the upper bits of B are ignored.
- R7: Opcode 0x0A gives the 16-bit immediate in bits 31:16 and zeros in bits 15:0. Operand A and `imm_sel` have no effect.
- R8: An opcode with bit 4 set and bit 3 clear is a signed compare. Bits 2:0 select the relation: 0 = A<B, 1 = A>B, 2 = A≤B, 3 = A≥B, 4 = A==B, 5 = A!=B. The result is 32'd1 when the relation holds and 32'd0 otherwise.
- R9: An opcode with bits 4 and 3 both set is the same set of compares with both operands treated as unsigned.
- R10: With `imm_sel`=1, operand B is the 16-bit immediate. It is sign-extended for signed add, signed subtract and signed compares, and zero-extended for the unsigned arithmetic forms, the logic operations, the shifts and the unsigned compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| imm_sel | input | 1 | 1: operand B from immediate, 0: from register |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Register operand B |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered signed overflow |

## Verification
Add and subtract are tried with small values, with values at the signed boundary, and with a wrap through zero. Running the same operands through the signed and unsigned forms separates the overflow report from the wrap result. Each relation is tried where the signed and unsigned orderings disagree (−1 against 1), and on equal operands, which separates the strict relations from the non-strict ones. Immediates with bit 15 set show whether each operation sign-extends or zero-extends. Shifts use counts with upper bits set and the full count of 31. A cycle with `in_valid` low checks that the output register holds its contents.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_ADD  = 5'h00;
  localparam logic [OP_W-1:0] OP_ADDU = 5'h01;
  localparam logic [OP_W-1:0] OP_SUB  = 5'h02;
  localparam logic [OP_W-1:0] OP_SUBU = 5'h03;
  localparam logic [OP_W-1:0] OP_AND  = 5'h04;
  localparam logic [OP_W-1:0] OP_OR   = 5'h05;
  localparam logic [OP_W-1:0] OP_XOR  = 5'h06;
  localparam logic [OP_W-1:0] OP_SLL  = 5'h07;
  localparam logic [OP_W-1:0] OP_SRL  = 5'h08;
  localparam logic [OP_W-1:0] OP_SRA  = 5'h09;
  localparam logic [OP_W-1:0] OP_LHI  = 5'h0A;

  typedef enum logic [2:0] {
    REL_LT = 3'd0,
    REL_GT = 3'd1,
    REL_LE = 3'd2,
    REL_GE = 3'd3,
    REL_EQ = 3'd4,
    REL_NE = 3'd5
  } rel_e;

  function automatic logic op_is_set(input logic [OP_W-1:0] o);
    return o[4];
  endfunction

  function automatic logic op_set_uns(input logic [OP_W-1:0] o);
    return o[4] & o[3];
  endfunction

  function automatic logic op_imm_signed(input logic [OP_W-1:0] o);
    return (o == OP_ADD) || (o == OP_SUB) || (o[4] && !o[3]);
  endfunction
endpackage

// File: rtl/intalu_opnd.sv
module intalu_opnd #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [intalu_pkg::OP_W-1:0] op,
  input  logic                        imm_sel,
  input  logic [DATA_W-1:0]           src_b,
  input  logic [IMM_W-1:0]            imm,
  output logic [DATA_W-1:0]           opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_zx;

  always_comb begin
    imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    imm_zx = {{EXT_W{1'b0}}, imm};
    if (!imm_sel)
      opnd_b = src_b;
    else if (intalu_pkg::op_imm_signed(op))
      opnd_b = imm_sx;
    else
      opnd_b = imm_zx;
  end
endmodule

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff   = sub ? ~b : b;
    sum     = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
    ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/intalu_cmp.sv
module intalu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              uns,
  input  logic [2:0]        rel,
  output logic              hit
);
  import intalu_pkg::*;

  logic lt;
  logic eq;

  always_comb begin
    eq = (a == b);
    if (uns)
      lt = (a < b);
    else
      lt = ($signed(a) < $signed(b));
    unique case (rel)
      REL_LT:  hit = lt;
      REL_GT:  hit = !lt && !eq;
      REL_LE:  hit = lt || eq;
      REL_GE:  hit = !lt;
      REL_EQ:  hit = eq;
      REL_NE:  hit = !eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [intalu_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]           a,
  input  logic [DATA_W-1:0]           b,
  input  logic [IMM_W-1:0]            imm,
  output logic [DATA_W-1:0]           res
);
  import intalu_pkg::*;

  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - IMM_W;

  logic [SH_W-1:0] shamt;

  always_comb begin
    shamt = b[SH_W-1:0];
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << shamt;
      OP_SRL:  res = a >> shamt;
      OP_SRA:  res = $unsigned($signed(a) >>> shamt);
      OP_LHI:  res = {imm, {LOW_W{1'b0}}};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/intalu_top.sv
module intalu_top #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [intalu_pkg::OP_W-1:0] op,
  input  logic                        imm_sel,
  input  logic [DATA_W-1:0]           src_a,
  input  logic [DATA_W-1:0]           src_b,
  input  logic [IMM_W-1:0]            imm,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           result,
  output logic                        ovf
);
  import intalu_pkg::*;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] as_sum;
  logic              as_ovf;
  logic              cmp_hit;
  logic [DATA_W-1:0] lg_res;
  logic              is_arith;
  logic              is_sub;
  logic              is_sgn;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ovf;

  intalu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .op(op), .imm_sel(imm_sel), .src_b(src_b), .imm(imm), .opnd_b(opnd_b)
  );

  intalu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(src_a), .b(opnd_b), .sub(is_sub), .sum(as_sum), .ovf_raw(as_ovf)
  );

  intalu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a(src_a), .b(opnd_b), .uns(op_set_uns(op)), .rel(op[2:0]), .hit(cmp_hit)
  );

  intalu_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_logic (
    .op(op), .a(src_a), .b(opnd_b), .imm(imm), .res(lg_res)
  );

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU);
    is_sub   = (op == OP_SUB) || (op == OP_SUBU);
    is_sgn   = (op == OP_ADD) || (op == OP_SUB);
    if (op_is_set(op))
      nxt_res = {{(DATA_W-1){1'b0}}, cmp_hit};
    else if (is_arith)
      nxt_res = as_sum;
    else
      nxt_res = lg_res;
    nxt_ovf = is_sgn && as_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        ovf    <= nxt_ovf;
      end
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !ovf));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ovf) && !out_valid));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OP_ADD && op != OP_SUB) |=> !ovf);

  // R7
  lhi_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_LHI) |=> (result[IMM_W-1:0] == '0));

  // R8
  set_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[4]) |=> (result[DATA_W-1:1] == '0));
endmodule

// File: tb/intalu_top_tb_top.sv
`timescale 1ns/1ps
module intalu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  op;
  logic        imm_sel;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [15:0] imm;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  intalu_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .imm_sel(imm_sel),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [4:0] o, input logic isel,
                     input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                     input logic [31:0] exp_res, input logic exp_ovf);
    @(negedge clk);
    in_valid = 1'b1; op = o; imm_sel = isel; src_a = a; src_b = b; imm = im;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " result"}, result, exp_res);
    check({tag, " ovf"}, {31'd0, ovf}, {31'd0, exp_ovf});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; op = '0; imm_sel = 1'b0;
    src_a = '0; src_b = '0; imm = '0;
    repeat (2) @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 ovf", {31'd0, ovf}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_arith;
    run("R3 add small",   5'h00, 0, 32'd5, 32'd7, 16'h0, 32'd12, 0);
    run("R4 add ovf",     5'h00, 0, 32'h7FFFFFFF, 32'd1, 16'h0, 32'h80000000, 1);
    run("R4 addu no ovf", 5'h01, 0, 32'h7FFFFFFF, 32'd1, 16'h0, 32'h80000000, 0);
    run("R4 sub ovf",     5'h02, 0, 32'h80000000, 32'd1, 16'h0, 32'h7FFFFFFF, 1);
    run("R3 sub small",   5'h02, 0, 32'd10, 32'd3, 16'h0, 32'd7, 0);
    run("R3 subu wrap",   5'h03, 0, 32'd0, 32'd1, 16'h0, 32'hFFFFFFFF, 0);
  endtask

  task automatic t_logic;
    run("R5 xor",         5'h06, 0, 32'hF0F0F0F0, 32'hFFFF0000, 16'h0, 32'h0F0FF0F0, 0);
    run("R10 andi zx",    5'h04, 1, 32'hFFFFFFFF, 32'h0, 16'hFF00, 32'h0000FF00, 0);
    run("R10 ori zx",     5'h05, 1, 32'h12340000, 32'hFFFFFFFF, 16'h8001, 32'h12348001, 0);
    run("R4 and no ovf",  5'h04, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 32'h7FFFFFFF, 0);
  endtask

  task automatic t_shift;
    run("R6 sll low5",    5'h07, 0, 32'd1, 32'h00000023, 16'h0, 32'd8, 0);
    run("R6 srl",         5'h08, 0, 32'h80000000, 32'd4, 16'h0, 32'h08000000, 0);
    run("R6 sra",         5'h09, 0, 32'h80000000, 32'd4, 16'h0, 32'hF8000000, 0);
    run("R6 srai 31",     5'h09, 1, 32'h80000000, 32'h0, 16'h001F, 32'hFFFFFFFF, 0);
    run("R6 srli 31",     5'h08, 1, 32'h80000000, 32'h0, 16'h001F, 32'h00000001, 0);
  endtask

  task automatic t_lhi;
    run("R7 lhi",         5'h0A, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 32'hABCD0000, 0);
    run("R7 lhi regsel",  5'h0A, 0, 32'h12345678, 32'h0, 16'h8001, 32'h80010000, 0);
  endtask

  task automatic t_imm_arith;
    run("R10 addi sx",    5'h00, 1, 32'd10, 32'h0, 16'hFFFF, 32'd9, 0);
    run("R10 addui zx",   5'h01, 1, 32'd10, 32'h0, 16'hFFFF, 32'h00010009, 0);
  endtask

  task automatic t_compare;
    run("R8 slt -1<1",    5'h10, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd1, 0);
    run("R9 sltu -1<1",   5'h18, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd0, 0);
    run("R8 sgt -1>1",    5'h11, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd0, 0);
    run("R9 sgtu -1>1",   5'h19, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd1, 0);
    run("R8 sle eq",      5'h12, 0, 32'd5, 32'd5, 16'h0, 32'd1, 0);
    run("R8 slt eq",      5'h10, 0, 32'd5, 32'd5, 16'h0, 32'd0, 0);
    run("R8 sge 4>=5",    5'h13, 0, 32'd4, 32'd5, 16'h0, 32'd0, 0);
    run("R8 seq",         5'h14, 0, 32'd5, 32'd5, 16'h0, 32'd1, 0);
    run("R8 sne",         5'h15, 0, 32'd5, 32'd5, 16'h0, 32'd0, 0);
    run("R9 sleu",        5'h1A, 0, 32'd3, 32'h80000000, 16'h0, 32'd1, 0);
    run("R9 sgeu eq",     5'h1B, 0, 32'd9, 32'd9, 16'h0, 32'd1, 0);
    run("R9 sneu",        5'h1D, 0, 32'd9, 32'd8, 16'h0, 32'd1, 0);
    run("R10 slti sx",    5'h10, 1, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 32'd1, 0);
    run("R10 slti pos",   5'h10, 1, 32'd5, 32'h0, 16'hFFFF, 32'd0, 0);
    run("R10 sltui zx",   5'h18, 1, 32'd5, 32'h0, 16'hFFFF, 32'd1, 0);
  endtask

  task automatic t_hold;
    run("R2 setup",       5'h00, 0, 32'd100, 32'd23, 16'h0, 32'd123, 0);
    @(negedge clk);
    in_valid = 1'b0; op = 5'h00; src_a = 32'h7FFFFFFF; src_b = 32'd1;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 hold result", result, 32'd123);
    check("R2 hold ovf", {31'd0, ovf}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_lhi();
    t_imm_arith();
    t_compare();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule